// File: doc/BRIEF.md
# Bipolar Zero-Substitution Receive Decoder

This block sits behind a T1 or E1 line receiver that presents one symbol per recovered clock as a pair of single-rail pulse indications, one for a positive mark and one for a negative mark. It tracks the polarity of the line, recognises the zero-substitution patterns that the far end inserts to keep long zero runs dense in marks, and puts those positions back to zeros. Every bipolar violation that does not belong to such a pattern is reported on a per-bit violation flag. When the substitution is unwanted, the block can be set to a transparent mode in which data passes unchanged and every bipolar violation is reported.

A fixed eight-symbol pipeline holds a whole substitution window, so a pattern can be judged in full before its first symbol leaves the block. The flag is aligned with the data. A saturating counter adds up flagged violations on the receive clock and is cleared by a read strobe. A small configuration register holds the dual-rail select and the decode enable, and a separate input picks T1 (8-symbol pattern) or E1 (4-symbol pattern) substitution.

Top module: `zsd_decoder`

## Requirements
- R1: A line symbol that is sampled at rising edge k appears on `data_o` and `viol_o` after rising edge k+8. A symbol is a mark when `line_pos_i` or `line_neg_i` is 1. Its polarity is positive when `line_pos_i` is 1, otherwise negative.
- R2: A bipolar violation is a mark whose polarity equals the polarity of the previous line mark. Marks that are part of a removed pattern count as line marks. The first mark after reset is never a violation.
- R3: When decoding is not active, `data_o` equals the mark bit of the delayed symbol and `viol_o` is 1 for every bipolar violation.
- R4: When decoding is active with `e1_mode_i`=0, and P is the polarity of the previous line mark, a run of eight symbols 0,0,0,P,~P,0,~P,P that starts at a symbol not already consumed is output as eight zeros with no flag.
- R5: When decoding is active with `e1_mode_i`=1, the four-symbol runs 0,0,0,P and ~P,0,0,~P are each output as four zeros with no flag. A run can only start at a symbol not already consumed, and only after at least one mark since reset.
- R6: When decoding is active, every bipolar violation that is not inside a removed pattern is output as a mark with `viol_o`=1.
- R7: While the dual-rail select bit is 1, the decode enable has no effect and the block behaves as in R3.
- R8: A cycle with `cfg_we_i`=1 loads the dual-rail select from `cfg_dual_i` and the decode enable from `cfg_decode_i`. Reset sets the dual-rail select to 0 and the decode enable to 1, and clears `data_o`, `viol_o` and the pipeline.
- R9: `viol_cnt_o` increases by one on each rising edge at which `viol_o` is 1.
- R10: `viol_cnt_o` holds at 65535 instead of wrapping.
- R11: A rising edge with `cnt_rd_i`=1 sets `viol_cnt_o` to 0, or to 1 if `viol_o` is 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos_i | input | 1 | Positive mark indication |
| line_neg_i | input | 1 | Negative mark indication |
| e1_mode_i | input | 1 | 1 selects E1 four-symbol substitution, 0 selects T1 eight-symbol |
| cfg_we_i | input | 1 | Load strobe for the configuration register |
| cfg_dual_i | input | 1 | Dual-rail select value to load |
| cfg_decode_i | input | 1 | Decode enable value to load |
| cnt_rd_i | input | 1 | Counter read strobe, clears the count |
| data_o | output | 1 | Decoded data, 8 symbols delayed |
| viol_o | output | 1 | Violation flag aligned with `data_o` |
| viol_cnt_o | output | 16 | Saturating violation count |

## Verification
The counter can receive a read strobe at the same edge at which a violation is flagged. It must then restart at one rather than lose the event or keep the old total. The bench provokes this after driving an unbroken train of same-polarity marks with decoding off. That train first drives the count to saturation. A read is then issued while `viol_o` is still 1, and the count is expected to be 1 at that edge and 2 at the next. A read on a quiet line is expected to give 0.

// File: rtl/zsd_pkg.sv
package zsd_pkg;

  localparam int unsigned T1_LEN = 8;
  localparam int unsigned E1_LEN = 4;
  localparam int unsigned WIN    = T1_LEN;

  localparam logic [WIN-1:0] T1_SPAN = '1;
  localparam logic [WIN-1:0] E1_SPAN = WIN'((1 << E1_LEN) - 1);

  typedef struct packed {
    logic mark;
    logic pol;
    logic sub;
  } zsym_t;

  function automatic logic is_zero(input zsym_t s);
    return !s.mark;
  endfunction

  function automatic logic is_mark(input zsym_t s, input logic p);
    return s.mark && (s.pol == p);
  endfunction

  // Eight-symbol run 0 0 0 V B 0 V B relative to previous polarity p
  function automatic logic t1_hit(input zsym_t [WIN-1:0] w, input logic p);
    return is_zero(w[0]) && is_zero(w[1]) && is_zero(w[2]) &&
           is_mark(w[3], p) && is_mark(w[4], !p) && is_zero(w[5]) &&
           is_mark(w[6], !p) && is_mark(w[7], p);
  endfunction

  // Four-symbol runs 0 0 0 V or B 0 0 V relative to previous polarity p
  function automatic logic e1_hit(input zsym_t [WIN-1:0] w, input logic p);
    logic run_a;
    logic run_b;
    run_a = is_zero(w[0]) && is_zero(w[1]) && is_zero(w[2]) && is_mark(w[3], p);
    run_b = is_mark(w[0], !p) && is_zero(w[1]) && is_zero(w[2]) &&
            is_mark(w[3], !p);
    return run_a || run_b;
  endfunction

endpackage

// File: rtl/zsd_window.sv
module zsd_window
  import zsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_mark,
  input  logic  in_pol,
  input  logic  dec_on,
  input  logic  e1_mode,
  input  logic  ref_pol,
  input  logic  ref_vld,
  output zsym_t head,
  output logic  hit
);

  zsym_t [WIN-1:0] win;
  logic [WIN-1:0]  span;
  logic            match;

  always_comb begin
    span  = e1_mode ? E1_SPAN : T1_SPAN;
    match = e1_mode ? e1_hit(win, ref_pol) : t1_hit(win, ref_pol);
    hit   = dec_on && ref_vld && !win[0].sub && match;
    head      = win[0];
    head.sub  = win[0].sub | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else begin
      for (int i = 0; i < WIN - 1; i++) begin
        win[i].mark <= win[i+1].mark;
        win[i].pol  <= win[i+1].pol;
        win[i].sub  <= win[i+1].sub | (hit & span[i+1]);
      end
      win[WIN-1].mark <= in_mark;
      win[WIN-1].pol  <= in_pol;
      win[WIN-1].sub  <= 1'b0;
    end
  end

endmodule

// File: rtl/zsd_classify.sv
module zsd_classify
  import zsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  zsym_t head,
  output logic  ref_pol,
  output logic  ref_vld,
  output logic  data_q,
  output logic  viol_q
);

  logic bpv;

  always_comb bpv = head.mark && ref_vld && (head.pol == ref_pol) && !head.sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pol <= 1'b0;
      ref_vld <= 1'b0;
      data_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      if (head.mark) begin
        ref_pol <= head.pol;
        ref_vld <= 1'b1;
      end
      data_q <= head.mark && !head.sub;
      viol_q <= bpv;
    end
  end

endmodule

// File: rtl/zsd_viol_counter.sv
module zsd_viol_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         rd,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input logic en);
    if (!en || v == TOP) return v;
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (rd) cnt <= bump('0, inc);
    else         cnt <= bump(cnt, inc);
  end

endmodule

// File: rtl/zsd_decoder.sv
module zsd_decoder
  import zsd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_pos_i,
  input  logic             line_neg_i,
  input  logic             e1_mode_i,
  input  logic             cfg_we_i,
  input  logic             cfg_dual_i,
  input  logic             cfg_decode_i,
  input  logic             cnt_rd_i,
  output logic             data_o,
  output logic             viol_o,
  output logic [CNT_W-1:0] viol_cnt_o
);

  logic  dual_q;
  logic  dec_q;
  logic  dec_on;
  logic  ref_pol;
  logic  ref_vld;
  logic  hit;
  logic  head_mark;
  zsym_t head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q <= 1'b0;
      dec_q  <= 1'b1;
    end else if (cfg_we_i) begin
      dual_q <= cfg_dual_i;
      dec_q  <= cfg_decode_i;
    end
  end

  always_comb begin
    dec_on    = dec_q && !dual_q;
    head_mark = head.mark;
  end

  zsd_window u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_mark (line_pos_i | line_neg_i),
    .in_pol  (line_pos_i),
    .dec_on  (dec_on),
    .e1_mode (e1_mode_i),
    .ref_pol (ref_pol),
    .ref_vld (ref_vld),
    .head    (head),
    .hit     (hit)
  );

  zsd_classify u_cls (
    .clk     (clk),
    .rst_n   (rst_n),
    .head    (head),
    .ref_pol (ref_pol),
    .ref_vld (ref_vld),
    .data_q  (data_o),
    .viol_q  (viol_o)
  );

  zsd_viol_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (viol_o),
    .rd    (cnt_rd_i),
    .cnt   (viol_cnt_o)
  );

endmodule

// File: rtl/zsd_checker.sv
module zsd_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit,
  input logic             dec_on,
  input logic             head_mark,
  input logic             data_o,
  input logic             viol_o,
  input logic             rd,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // R4 / R5: a recognised run leaves as a zero with no flag
  p_pattern_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!data_o && !viol_o));

  // R3: in transparent mode every mark reaches the output
  p_bypass_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_on && head_mark) |=> data_o);

  // R9: one step per flagged violation
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && !rd && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  // R10: saturation
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !rd) |=> (cnt == TOP));

  // R11: read clears, keeping a coincident violation
  p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (cnt == CNT_W'($past(viol_o))));

  // R9: without a flag or a read the count holds
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol_o && !rd) |=> $stable(cnt));

endmodule

bind zsd_decoder zsd_checker #(.CNT_W(CNT_W)) u_zsd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit       (hit),
  .dec_on    (dec_on),
  .head_mark (head_mark),
  .data_o    (data_o),
  .viol_o    (viol_o),
  .rd        (cnt_rd_i),
  .cnt       (viol_cnt_o)
);

// File: tb/test_zsd_decoder.sv
`timescale 1ns/1ps
module test_zsd_decoder;

  localparam int CW   = 16;
  localparam int MAXC = 65535;
  localparam int ASZ  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_pos_i = 1'b0, line_neg_i = 1'b0, e1_mode_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_dual_i = 1'b0, cfg_decode_i = 1'b0, cnt_rd_i = 1'b0;
  logic data_o, viol_o;
  logic [CW-1:0] viol_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit sm [ASZ];
  bit sp [ASZ];
  bit od [ASZ];
  bit ed [ASZ];
  bit ev [ASZ];
  int exp_sum;

  always #2 clk = ~clk;

  zsd_decoder i_zsd_decoder (
    .clk(clk), .rst_n(rst_n), .line_pos_i(line_pos_i), .line_neg_i(line_neg_i),
    .e1_mode_i(e1_mode_i), .cfg_we_i(cfg_we_i), .cfg_dual_i(cfg_dual_i),
    .cfg_decode_i(cfg_decode_i), .cnt_rd_i(cnt_rd_i), .data_o(data_o),
    .viol_o(viol_o), .viol_cnt_o(viol_cnt_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_pos_i = 0; line_neg_i = 0; cnt_rd_i = 0; cfg_we_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input bit dual, input bit dec);
    @(negedge clk);
    cfg_we_i = 1; cfg_dual_i = dual; cfg_decode_i = dec;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic clear_tail(input int n);
    for (int i = n; i < ASZ; i++) begin sm[i] = 0; sp[i] = 0; od[i] = 0; end
  endtask

  // Random line symbols, no symbol with both indications
  task automatic gen_random(input int n, input bit lead_pos);
    for (int i = 0; i < n; i++) begin
      sm[i] = ($urandom % 3) != 0;
      sp[i] = $urandom % 2;
    end
    if (lead_pos) begin sm[0] = 1; sp[0] = 1; sm[1] = 1; sp[1] = 1; end
    clear_tail(n);
  endtask

  // Encode sparse random data with the substitution rules
  task automatic gen_encoded(input bit e1, input int n);
    bit lp = 0;
    int par = 0;
    int i = 0;
    for (int k = 0; k < n; k++) od[k] = (($urandom % 4) == 0);
    od[0] = 1;
    clear_tail(n);
    while (i < n) begin
      bit zrun = 1;
      int len = e1 ? 4 : 8;
      if (i + len > n) zrun = 0;
      else for (int k = 0; k < len; k++) if (od[i+k]) zrun = 0;
      if (zrun && !e1) begin
        sm[i] = 0; sm[i+1] = 0; sm[i+2] = 0;
        sm[i+3] = 1; sp[i+3] = lp;  sm[i+4] = 1; sp[i+4] = !lp;
        sm[i+5] = 0; sm[i+6] = 1; sp[i+6] = !lp; sm[i+7] = 1; sp[i+7] = lp;
        i += 8;
      end else if (zrun && e1) begin
        sm[i+1] = 0; sm[i+2] = 0;
        if (par % 2 == 1) begin
          sm[i] = 0; sm[i+3] = 1; sp[i+3] = lp;
        end else begin
          lp = !lp; sm[i] = 1; sp[i] = lp; sm[i+3] = 1; sp[i+3] = lp;
        end
        par = 0;
        i += 4;
      end else begin
        if (od[i]) begin lp = !lp; sm[i] = 1; sp[i] = lp; par++; end
        else sm[i] = 0;
        i++;
      end
    end
  endtask

  // Expected output from the requirements, scanning the stored stream
  task automatic ref_decode(input bit e1, input bit dec, input int n);
    bit pv = 0, pp = 0;
    int i = 0;
    int len = e1 ? 4 : 8;
    exp_sum = 0;
    while (i < n + 8) begin
      bit m = 0;
      if (dec && pv) begin
        if (!e1)
          m = !sm[i] && !sm[i+1] && !sm[i+2] && sm[i+3] && sp[i+3] == pp &&
              sm[i+4] && sp[i+4] != pp && !sm[i+5] && sm[i+6] && sp[i+6] != pp &&
              sm[i+7] && sp[i+7] == pp;
        else
          m = (!sm[i] && !sm[i+1] && !sm[i+2] && sm[i+3] && sp[i+3] == pp) ||
              (sm[i] && sp[i] != pp && !sm[i+1] && !sm[i+2] && sm[i+3] && sp[i+3] == sp[i]);
      end
      if (m) begin
        for (int k = 0; k < len; k++) begin
          ed[i+k] = 0; ev[i+k] = 0;
          if (sm[i+k]) pp = sp[i+k];
        end
        i += len;
      end else begin
        ed[i] = sm[i];
        ev[i] = sm[i] && pv && (sp[i] == pp);
        if (ev[i]) exp_sum++;
        if (sm[i]) begin pv = 1; pp = sp[i]; end
        i++;
      end
    end
  endtask

  // Drive the stream and compare each symbol eight edges later (R1)
  task automatic run_stream(input string req, input int n, input bit cmp_orig);
    for (int t = 0; t <= n + 9; t++) begin
      @(negedge clk);
      if (t >= 9 && (t - 9) < n) begin
        chk(req, $sformatf("R1 data sym %0d", t - 9), data_o, ed[t-9]);
        chk(req, $sformatf("R1 flag sym %0d", t - 9), viol_o, ev[t-9]);
        if (cmp_orig) chk(req, $sformatf("orig data sym %0d", t - 9), data_o, od[t-9]);
      end
      line_pos_i = sm[t] && sp[t];
      line_neg_i = sm[t] && !sp[t];
    end
    line_pos_i = 0; line_neg_i = 0;
    repeat (10) @(negedge clk);
    chk("R9", {req, " count"}, viol_cnt_o, (exp_sum > MAXC) ? MAXC : exp_sum);
    cnt_rd_i = 1;
    @(negedge clk);
    cnt_rd_i = 0;
    chk("R11", "quiet read clears", viol_cnt_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4127));

    // R8: reset state, defaults give T1 decoding
    do_reset();
    chk("R8", "reset data", data_o, 0);
    chk("R8", "reset flag", viol_o, 0);
    chk("R9", "reset count", viol_cnt_o, 0);
    e1_mode_i = 0;
    gen_encoded(0, 400); ref_decode(0, 1, 400);
    run_stream("R4", 400, 1);

    // R5: E1 runs with default configuration
    do_reset(); e1_mode_i = 1;
    gen_encoded(1, 400); ref_decode(1, 1, 400);
    run_stream("R5", 400, 1);

    // R6: residual violations with decoding on
    do_reset(); e1_mode_i = 0;
    gen_random(300, 0); ref_decode(0, 1, 300);
    run_stream("R6", 300, 0);
    do_reset(); e1_mode_i = 1;
    gen_random(300, 0); ref_decode(1, 1, 300);
    run_stream("R6", 300, 0);

    // R3: transparent mode passes substitution marks and flags them
    do_reset(); e1_mode_i = 0; cfg(0, 0);
    gen_encoded(0, 400); ref_decode(0, 0, 400);
    chk("R3", "patterns present", (exp_sum > 0) ? 1 : 0, 1);
    run_stream("R3", 400, 0);

    // R7: dual-rail select overrides decode enable
    do_reset(); e1_mode_i = 1; cfg(1, 1);
    gen_encoded(1, 400); ref_decode(1, 0, 400);
    run_stream("R7", 400, 0);

    // R2: first mark is never flagged, second same-polarity one is
    do_reset(); e1_mode_i = 0; cfg(0, 0);
    gen_random(300, 1); ref_decode(0, 0, 300);
    chk("R2", "first mark expectation", ev[0], 0);
    chk("R2", "second mark expectation", ev[1], 1);
    run_stream("R2", 300, 0);

    // R10 / R11: saturation, then read coinciding with a violation
    do_reset(); cfg(0, 0);
    line_pos_i = 1;
    repeat (MAXC + 12) @(negedge clk);
    chk("R10", "saturated count", viol_cnt_o, MAXC);
    @(negedge clk);
    chk("R10", "held at top", viol_cnt_o, MAXC);
    chk("R11", "flag high before read", viol_o, 1);
    cnt_rd_i = 1;
    @(negedge clk);
    cnt_rd_i = 0;
    chk("R11", "read with coincident violation", viol_cnt_o, 1);
    @(negedge clk);
    chk("R9", "count after read", viol_cnt_o, 2);
    line_pos_i = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule